// File: doc/BRIEF.md
# Segmented Carry-Predicting Approximate Adder

This block is an unsigned approximate adder built from combinational logic. It takes two `WIDTH`-bit operands and splits them into `WIDTH/SEG` equal segments of `SEG` bits. Each segment adds its own operand bits exactly, using a short ripple chain.

A segment does not wait for the carry to ripple up from the whole lower part of the word. It gets its carry-in from a small predictor. The predictor looks only at the two segments directly below and works out whether that span alone would carry out. Because of this, no carry path is longer than three segments. The price is that a carry which has to travel further than two segments is lost, and the sum then has an error.

The block is meant for datapaths that can tolerate errors, where a shorter carry path is worth a rare, large error. Wider segments give a more accurate result. If `SEG` is less than 1, or `WIDTH` is not a whole multiple of `SEG`, elaboration stops with an error.

Top module: `etseg_adder`

## Requirements
- R1: The lowest segment has a carry-in of zero, so `sum[SEG-1:0]` always equals the low `SEG` bits of `op_a + op_b`.
- R2: The carry into segment 1 is taken from segment 0 alone, so `sum[2*SEG-1:0]` always equals the low `2*SEG` bits of `op_a + op_b`.
- R3: For a segment i of 2 or more (bits `[i*SEG +: SEG]`), the output field is `(a_i + b_i + c_i) mod 2^SEG`. Here `c_i` is the carry out of the span `[(i-2)*SEG +: 2*SEG]` added on its own with a carry-in of zero. This holds for WIDTH/SEG of 8/2, 16/2 and 16/4.
- R4: Whenever every true carry into a segment matches its predicted carry-in, `sum` equals `(op_a + op_b) mod 2^WIDTH`. For example, operands that have no set bit in common always give the exact sum `op_a | op_b`.
- R5: The result is `WIDTH` bits wide and the carry out of the top segment is dropped. For example, with WIDTH=8, `0xC0 + 0x40` gives `0x00`.
- R6: The block is purely combinational. `sum` follows a change on `op_a`/`op_b` within the same clock period, with no clock and no state.
- R7: Over the same set of random operand pairs with WIDTH=16, segments of 4 bits give no more inexact results than segments of 2 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| sum | output | WIDTH | Approximate sum, carry out of the top dropped |

## Verification
There are no registers between the operands and `sum`, so every result is due in the same cycle as its stimulus. The bench changes the operands just after a falling clock edge and reads `sum` 2 ns later, which is well clear of the next rising edge. Each check therefore reads the result of the operand pair applied just before it, and no check waits on a pipeline. The vector table, the directed carry-chain cases and the random comparison against a model of the requirements all follow this same apply-then-sample timing.

// File: rtl/etseg_pkg.sv
package etseg_pkg;

    // Source of a segment's carry-in, chosen from the segment index.
    typedef enum logic [1:0] {
        CIN_ZERO     = 2'd0,
        CIN_ONE_SEG  = 2'd1,
        CIN_TWO_SEGS = 2'd2
    } cin_src_e;

    // Generate/propagate pair of one bit position.
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    function automatic cin_src_e cin_source(input int seg_idx);
        if (seg_idx == 0)      return CIN_ZERO;
        else if (seg_idx == 1) return CIN_ONE_SEG;
        else                   return CIN_TWO_SEGS;
    endfunction

    function automatic gp_t bit_gp(input logic a, input logic b);
        gp_t r;
        r.gen  = a & b;
        r.prop = a ^ b;
        return r;
    endfunction

    function automatic logic carry_step(input gp_t g, input logic cin);
        return g.gen | (g.prop & cin);
    endfunction

endpackage

// File: rtl/etseg_segment.sv
module etseg_segment
    import etseg_pkg::*;
#(
    parameter int W = 2
) (
    input  logic [W-1:0] seg_a,
    input  logic [W-1:0] seg_b,
    input  logic         seg_cin,
    output logic [W-1:0] seg_sum,
    output logic         seg_cout
);

    logic [W:0] chain;
    gp_t  [W-1:0] gp;

    assign chain[0] = seg_cin;

    for (genvar j = 0; j < W; j++) begin : g_bit
        assign gp[j]        = bit_gp(seg_a[j], seg_b[j]);
        assign seg_sum[j]   = gp[j].prop ^ chain[j];
        assign chain[j+1]   = carry_step(gp[j], chain[j]);
    end

    assign seg_cout = chain[W];

    // R3: the ripple chain must equal the arithmetic segment sum
    always_comb begin
        if (!$isunknown({seg_a, seg_b, seg_cin})) begin
            p_seg_exact_r3: assert ({seg_cout, seg_sum} ==
                                    ({1'b0, seg_a} + {1'b0, seg_b} + (W+1)'(seg_cin)))
                else $error("segment ripple sum mismatch");
        end
    end

endmodule

// File: rtl/etseg_carry_predict.sv
module etseg_carry_predict
    import etseg_pkg::*;
#(
    parameter int SPAN = 4
) (
    input  logic [SPAN-1:0] span_a,
    input  logic [SPAN-1:0] span_b,
    output logic            carry_pred
);

    logic [SPAN:0] k;
    assign k[0] = 1'b0;

    for (genvar j = 0; j < SPAN; j++) begin : g_scan
        assign k[j+1] = carry_step(bit_gp(span_a[j], span_b[j]), k[j]);
    end

    assign carry_pred = k[SPAN];

    // R3: the prediction is the carry out of the span with a zero carry-in
    always_comb begin
        if (!$isunknown({span_a, span_b})) begin
            p_pred_carry_r3: assert (carry_pred ==
                                     (({1'b0, span_a} + {1'b0, span_b}) >> SPAN))
                else $error("carry prediction mismatch");
        end
    end

endmodule

// File: rtl/etseg_adder.sv
module etseg_adder
    import etseg_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int SEG   = 2
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum
);

    localparam int NSEG = (SEG > 0) ? WIDTH / SEG : 1;

    if (SEG < 1 || WIDTH < SEG || (WIDTH % SEG) != 0) begin : g_bad_params
        $error("etseg_adder: WIDTH must be a positive multiple of SEG");
    end

    logic [NSEG-1:0] seg_cin;
    logic [NSEG-1:0] seg_cout;
    logic [NSEG-1:0] true_cin;

    for (genvar i = 0; i < NSEG; i++) begin : g_seg
        localparam cin_src_e SRC = cin_source(i);

        if (SRC == CIN_ZERO) begin : g_cin_zero
            assign seg_cin[i] = 1'b0;
        end else if (SRC == CIN_ONE_SEG) begin : g_cin_one
            // segment 0 runs with a zero carry-in, so its carry out is the prediction
            assign seg_cin[i] = seg_cout[0];
        end else begin : g_cin_two
            etseg_carry_predict #(.SPAN(2*SEG)) i_pred (
                .span_a     (op_a[(i-2)*SEG +: 2*SEG]),
                .span_b     (op_b[(i-2)*SEG +: 2*SEG]),
                .carry_pred (seg_cin[i])
            );
        end

        etseg_segment #(.W(SEG)) i_seg (
            .seg_a    (op_a[i*SEG +: SEG]),
            .seg_b    (op_b[i*SEG +: SEG]),
            .seg_cin  (seg_cin[i]),
            .seg_sum  (sum[i*SEG +: SEG]),
            .seg_cout (seg_cout[i])
        );

        // Exact carry into this segment, used only by the checks below
        if (i == 0) begin : g_true0
            assign true_cin[i] = 1'b0;
        end else begin : g_true
            logic [i*SEG:0] part;
            assign part        = {1'b0, op_a[i*SEG-1:0]} + {1'b0, op_b[i*SEG-1:0]};
            assign true_cin[i] = part[i*SEG];
        end
    end

    always_comb begin
        if (!$isunknown({op_a, op_b})) begin
            // R1: bottom segment is always exact
            p_low_seg_exact_r1: assert (sum[SEG-1:0] == SEG'(op_a + op_b))
                else $error("lowest segment inexact");
            if (NSEG > 1) begin
                // R2: bottom two segments are always exact
                p_low_pair_exact_r2: assert (true_cin[NSEG > 1 ? 1 : 0] == seg_cin[NSEG > 1 ? 1 : 0])
                    else $error("carry into segment 1 differs from true carry");
            end
            // R4 / R5: matching carries give the exact sum modulo 2^WIDTH
            if (seg_cin == true_cin) begin
                p_exact_when_short_r4: assert (sum == WIDTH'(op_a + op_b))
                    else $error("sum inexact although all carries predicted");
            end
        end
    end

endmodule

// File: tb/test_etseg_adder.sv
`timescale 1ns/1ps
module test_etseg_adder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [7:0]  a8, b8, s8;
    logic [15:0] a16, b16, s16x2, s16x4;

    etseg_adder #(.WIDTH(8),  .SEG(2)) i_etseg_adder (.op_a(a8),  .op_b(b8),  .sum(s8));
    etseg_adder #(.WIDTH(16), .SEG(2)) i_etseg_adder_w16s2 (.op_a(a16), .op_b(b16), .sum(s16x2));
    etseg_adder #(.WIDTH(16), .SEG(4)) i_etseg_adder_w16s4 (.op_a(a16), .op_b(b16), .sum(s16x4));

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // {a, b, expected} for WIDTH=8, SEG=2
    localparam int NVEC = 10;
    localparam logic [23:0] VEC [NVEC] = '{
        {8'h00, 8'h00, 8'h00},  // zero
        {8'h15, 8'h2A, 8'h3F},  // no carries (R4)
        {8'hFF, 8'h01, 8'hC0},  // long chain cut (R3)
        {8'hC0, 8'h40, 8'h00},  // top carry dropped (R5)
        {8'h03, 8'h01, 8'h04},  // carry seg0->seg1 (R2)
        {8'h0F, 8'h01, 8'h10},  // carry across two segments, exact (R4)
        {8'h3F, 8'h01, 8'h00},  // three-segment chain lost (R3)
        {8'hAA, 8'h55, 8'hFF},  // disjoint bits (R4)
        {8'h80, 8'h80, 8'h00},  // top carry dropped (R5)
        {8'h36, 8'h0A, 8'h00}   // predicted span misses carry (R3)
    };

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Independent model of the requirements (R1, R2, R3, R5)
    function automatic longint unsigned model(input longint unsigned a, input longint unsigned b,
                                              input int n, input int x);
        longint unsigned m  = (64'd1 << x) - 1;
        longint unsigned m2 = (64'd1 << (2*x)) - 1;
        longint unsigned r  = 0;
        for (int i = 0; i < n / x; i++) begin
            longint unsigned sa = (a >> (i*x)) & m;
            longint unsigned sb = (b >> (i*x)) & m;
            longint unsigned c;
            if (i == 0)      c = 0;
            else if (i == 1) c = ((a & m) + (b & m)) >> x;
            else             c = (((a >> ((i-2)*x)) & m2) + ((b >> ((i-2)*x)) & m2)) >> (2*x);
            r |= ((sa + sb + c) & m) << (i*x);
        end
        return r;
    endfunction

    task automatic apply8(input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        a8 = a; b8 = b;
        #2;
    endtask

    task automatic apply16(input logic [15:0] a, input logic [15:0] b);
        @(negedge clk);
        a16 = a; b16 = b;
        #2;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int err2, err4, err8;
        a8 = '0; b8 = '0; a16 = '0; b16 = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #2;
        // Reset state: zero operands give zero sums (R1, R6)
        check("R1 reset zero 8/2", s8, 0);
        check("R6 reset zero 16/2", s16x2, 0);
        check("R6 reset zero 16/4", s16x4, 0);

        // Vector table walk (R1 R2 R3 R4 R5)
        for (int v = 0; v < NVEC; v++) begin
            apply8(VEC[v][23:16], VEC[v][15:8]);
            check($sformatf("R3 table entry %0d", v), s8, VEC[v][7:0]);
        end

        // R6: same-period response to back-to-back operand changes
        apply8(8'h01, 8'h01);
        check("R6 same-cycle update", s8, 8'h02);
        apply8(8'h02, 8'h02);
        check("R6 same-cycle update", s8, 8'h04);

        // R1/R2 low fields exact on a long chain
        apply16(16'hFFFF, 16'h0001);
        check("R1 low seg exact 16/2", s16x2[1:0], 0);
        check("R2 low pair exact 16/4", s16x4[7:0], 0);
        // Directed long chains (R3)
        apply16(16'h00FF, 16'h0001);
        check("R3 chain cut 16/2", s16x2, 16'h00C0);
        apply16(16'h0FFF, 16'h0001);
        check("R3 chain cut 16/4", s16x4, 16'h0000);
        apply16(16'h00FF, 16'h0001);
        check("R4 two-seg carry exact 16/4", s16x4, 16'h0100);
        // R5 on 16-bit
        apply16(16'h8000, 16'h8000);
        check("R5 top carry dropped 16/4", s16x4, 0);

        // R4: disjoint operands always exact
        for (int k = 0; k < 200; k++) begin
            logic [15:0] ra = 16'($urandom);
            logic [15:0] rb = 16'($urandom) & ~ra;
            apply16(ra, rb);
            check("R4 disjoint 16/2", s16x2, ra | rb);
            check("R4 disjoint 16/4", s16x4, ra | rb);
        end

        // Random comparison against the model and error-rate measurement (R3, R7)
        err2 = 0; err4 = 0; err8 = 0;
        for (int k = 0; k < 2000; k++) begin
            logic [15:0] ra = 16'($urandom);
            logic [15:0] rb = 16'($urandom);
            apply16(ra, rb);
            check("R3 random 16/2", s16x2, model(ra, rb, 16, 2));
            check("R3 random 16/4", s16x4, model(ra, rb, 16, 4));
            if (s16x2 != 16'(ra + rb)) err2++;
            if (s16x4 != 16'(ra + rb)) err4++;
            apply8(ra[7:0], rb[7:0]);
            check("R3 random 8/2", s8, model(ra[7:0], rb[7:0], 8, 2));
            if (s8 != 8'(ra[7:0] + rb[7:0])) err8++;
        end
        $display("error rate per 2000: 8/2=%0d 16/2=%0d 16/4=%0d", err8, err2, err4);
        check("R7 wider segments no less accurate", longint'(err4 <= err2), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule